// File: doc/BRIEF.md
# Multi-core IPI and mailbox controller

This block delivers inter-processor interrupts and mailbox words among a small cluster of cores. Each core owns a set of registers: a 32-bit pending-vector status word, an enable word that gates it onto the core's interrupt line, a write-one-to-clear register, and eight 32-bit mailbox words. The eight words form four 64-bit mailboxes.

Several senders share a 64-bit command port. A command word names the target core, and either a vector number to raise or a mailbox word to fill. A mailbox fill can keep selected bytes of the word already stored. When two senders target the same core in the same cycle, the lower-indexed sender is served first and the other is held off through its ready output. Commands that are malformed or that target a core that does not exist are accepted and dropped.

Top module: `ipi_mbox_ctrl`

## Requirements
- R1: After reset, every status word and every mailbox word is zero, every enable word is all ones, and every interrupt output is low.
- R2: A send at command offset 0x00, of any access size, sets status bit `data[4:0]` of the core numbered `data[25:16]`. The bit is visible the cycle after the command is accepted.
- R3: Each core's interrupt output is high exactly when its status word ANDed with its enable word is nonzero. The enable word reads and writes at register offset 0x04. The status word reads at 0x00.
- R4: A write to register offset 0x08 clears the status bits written as 1. If an IPI send sets the same bit in the same cycle, the set wins. Offset 0x08 reads as zero.
- R5: A send at command offset 0x08 with an 8-byte access writes mailbox word `data[4:2]` of the target core. The payload is `data[63:32]`. With keep mask `data[30:27]` equal to zero, the full payload is stored.
- R6: With a nonzero keep mask, byte lane i of the stored word keeps its old value when mask bit i is set, and takes payload byte i when the bit is clear.
- R7: A mail send narrower than 8 bytes, a command at any offset other than 0x00 or 0x08, and a command whose target is not below the core count are all accepted with ready high and change no state.
- R8: When several valid commands name the same existing core in one cycle, only the lowest-indexed sender sees ready high. The others see ready low and have no effect. Commands to different cores in the same cycle are all accepted.
- R9: Mailbox word k reads at register offset 0x20 + 4*k. Reads at unmapped register offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_valid | input | NSEND | Command valid, one per sender |
| snd_size8 | input | NSEND | High when the access is 8 bytes wide |
| snd_addr | input | NSEND*8 | Command offset, one byte per sender |
| snd_data | input | NSEND*64 | Command word, 64 bits per sender |
| snd_ready | output | NSEND | Command accepted in this cycle when valid is high |
| reg_we | input | NCORES | Register write strobe, one per core |
| reg_addr | input | NCORES*8 | Register offset, one byte per core |
| reg_wdata | input | NCORES*32 | Register write data |
| reg_rdata | output | NCORES*32 | Combinational register read data |
| irq | output | NCORES | Interrupt line, one per core |

## Verification
The assertions check on every cycle that:
- an accepted IPI send lands in the status word;
- a clear that does not collide with a set leaves no written bit pending;
- an unmasked mail send stores its payload exactly, and a fully masked one leaves the word unchanged;
- at most one sender reaches any one core;
- a dropped command never stalls;
- the interrupt line rises only after a send or an enable write.

Only the bench scenarios show the rest: partial byte merges against the prior contents, the set-over-clear collision, the readback map, and the effect of the enable mask on the interrupt line. The bench compares these against a separate model over mixed random traffic.

// File: rtl/ipi_mbox_pkg.sv
package ipi_mbox_pkg;
  localparam int TGT_W  = 10;
  localparam int VEC_W  = 5;
  localparam int SLOT_W = 3;
  localparam int NSLOT  = 1 << SLOT_W;
  localparam int WORD_W = 32;

  localparam logic [7:0] CMD_OFF_IPI  = 8'h00;
  localparam logic [7:0] CMD_OFF_MAIL = 8'h08;

  localparam logic [7:0] REG_OFF_STAT = 8'h00;
  localparam logic [7:0] REG_OFF_EN   = 8'h04;
  localparam logic [7:0] REG_OFF_CLR  = 8'h08;
  localparam logic [2:0] REG_MBX_HI   = 3'b001;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_IPI  = 2'd1,
    CMD_MAIL = 2'd2
  } cmd_kind_e;

  typedef struct packed {
    cmd_kind_e          kind;
    logic [TGT_W-1:0]   target;
    logic [VEC_W-1:0]   vec;
    logic [SLOT_W-1:0]  slot;
    logic [WORD_W-1:0]  payload;
    logic [3:0]         keep;
  } send_cmd_t;

  // Expand a per-byte keep mask to a 32-bit lane mask
  function automatic logic [WORD_W-1:0] keep_lanes(input logic [3:0] keep);
    logic [WORD_W-1:0] m;
    for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{keep[b]}};
    return m;
  endfunction

  // Kept lanes come from the old word, the rest from the payload
  function automatic logic [WORD_W-1:0] mail_merge(input logic [WORD_W-1:0] old_w,
                                                   input logic [WORD_W-1:0] pay,
                                                   input logic [3:0] keep);
    logic [WORD_W-1:0] m;
    m = keep_lanes(keep);
    return (old_w & m) | (pay & ~m);
  endfunction
endpackage

// File: rtl/ipi_send_decode.sv
module ipi_send_decode
  import ipi_mbox_pkg::*;
#(
  parameter int NCORES = 4
) (
  input  logic        valid,
  input  logic        size8,
  input  logic [7:0]  addr,
  input  logic [63:0] data,
  output send_cmd_t   cmd
);
  logic [TGT_W-1:0] tgt;
  logic             tgt_ok;

  assign tgt    = data[25:16];
  assign tgt_ok = ({22'd0, tgt} < NCORES);

  always_comb begin
    cmd.target  = tgt;
    cmd.vec     = data[4:0];
    cmd.slot    = data[4:2];
    cmd.payload = data[63:32];
    cmd.keep    = data[30:27];
    cmd.kind    = CMD_NONE;
    if (valid && tgt_ok) begin
      if (addr == CMD_OFF_IPI)                cmd.kind = CMD_IPI;
      else if (addr == CMD_OFF_MAIL && size8) cmd.kind = CMD_MAIL;
    end
  end
endmodule

// File: rtl/ipi_target_arb.sv
module ipi_target_arb
  import ipi_mbox_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int NSEND  = 2
) (
  input  send_cmd_t         cmd      [NSEND],
  output logic [NSEND-1:0]  ready,
  output logic [NSEND-1:0]  granted,
  output logic [NCORES-1:0] hit,
  output send_cmd_t         core_cmd [NCORES]
);
  logic [NSEND-1:0] req;
  logic [NSEND-1:0] blocked;

  always_comb begin
    for (int s = 0; s < NSEND; s++) begin
      req[s]     = (cmd[s].kind != CMD_NONE);
      blocked[s] = 1'b0;
    end
    for (int s = 1; s < NSEND; s++)
      for (int t = 0; t < s; t++)
        if (req[s] && req[t] && cmd[t].target == cmd[s].target) blocked[s] = 1'b1;
  end

  assign ready   = ~blocked;
  assign granted = req & ~blocked;

  for (genvar c = 0; c < NCORES; c++) begin : g_sel
    always_comb begin
      hit[c]      = 1'b0;
      core_cmd[c] = '0;
      for (int s = NSEND - 1; s >= 0; s--) begin
        if (granted[s] && cmd[s].target == TGT_W'(c)) begin
          hit[c]      = 1'b1;
          core_cmd[c] = cmd[s];
        end
      end
    end
  end
endmodule

// File: rtl/ipi_core_regs.sv
module ipi_core_regs
  import ipi_mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  send_cmd_t         cmd,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq
);
  logic [WORD_W-1:0]             status;
  logic [WORD_W-1:0]             enable;
  logic [NSLOT-1:0][WORD_W-1:0]  mbx;

  logic              ipi_fire;
  logic              mail_fire;
  logic              clr_wr;
  logic              en_wr;
  logic [VEC_W-1:0]  ipi_vec;
  logic [SLOT_W-1:0] mail_slot;
  logic [WORD_W-1:0] set_bits;
  logic [WORD_W-1:0] clr_bits;

  assign ipi_fire  = hit && cmd.kind == CMD_IPI;
  assign mail_fire = hit && cmd.kind == CMD_MAIL;
  assign ipi_vec   = cmd.vec;
  assign mail_slot = cmd.slot;
  assign clr_wr    = reg_we && reg_addr == REG_OFF_CLR;
  assign en_wr     = reg_we && reg_addr == REG_OFF_EN;
  assign set_bits  = ipi_fire ? (WORD_W'(1) << ipi_vec) : '0;
  assign clr_bits  = clr_wr ? reg_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '1;
      mbx    <= '0;
    end else begin
      status <= (status & ~clr_bits) | set_bits;
      if (en_wr) enable <= reg_wdata;
      if (mail_fire) mbx[mail_slot] <= mail_merge(mbx[mail_slot], cmd.payload, cmd.keep);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == REG_OFF_STAT)    reg_rdata = status;
    else if (reg_addr == REG_OFF_EN) reg_rdata = enable;
    else if (reg_addr[7:5] == REG_MBX_HI && reg_addr[1:0] == 2'b00)
      reg_rdata = mbx[reg_addr[4:2]];
  end

  assign irq = |(status & enable);

  // R2
  ipi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_fire |=> status[$past(ipi_vec)]);

  // R4
  clear_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && !ipi_fire |=> (status & $past(reg_wdata)) == '0);

  // R5
  mail_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mail_fire && cmd.keep == 4'h0 |=> mbx[$past(mail_slot)] == $past(cmd.payload));

  // R6
  mail_keep_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mail_fire && cmd.keep == 4'hF |=> mbx[$past(mail_slot)] == $past(mbx[mail_slot]));

  // R3
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ipi_fire) || $past(en_wr));
endmodule

// File: rtl/ipi_mbox_ctrl.sv
module ipi_mbox_ctrl
  import ipi_mbox_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int NSEND  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSEND-1:0]         snd_valid,
  input  logic [NSEND-1:0]         snd_size8,
  input  logic [NSEND*8-1:0]       snd_addr,
  input  logic [NSEND*64-1:0]      snd_data,
  output logic [NSEND-1:0]         snd_ready,
  input  logic [NCORES-1:0]        reg_we,
  input  logic [NCORES*8-1:0]      reg_addr,
  input  logic [NCORES*WORD_W-1:0] reg_wdata,
  output logic [NCORES*WORD_W-1:0] reg_rdata,
  output logic [NCORES-1:0]        irq
);
  send_cmd_t        cmd      [NSEND];
  send_cmd_t        core_cmd [NCORES];
  logic [NSEND-1:0]  granted;
  logic [NCORES-1:0] hit;

  for (genvar s = 0; s < NSEND; s++) begin : g_dec
    ipi_send_decode #(.NCORES(NCORES)) u_dec (
      .valid (snd_valid[s]),
      .size8 (snd_size8[s]),
      .addr  (snd_addr[s*8 +: 8]),
      .data  (snd_data[s*64 +: 64]),
      .cmd   (cmd[s])
    );

    // R7
    drop_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snd_valid[s] && cmd[s].kind == CMD_NONE |-> snd_ready[s]);
  end

  ipi_target_arb #(.NCORES(NCORES), .NSEND(NSEND)) u_arb (
    .cmd      (cmd),
    .ready    (snd_ready),
    .granted  (granted),
    .hit      (hit),
    .core_cmd (core_cmd)
  );

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    logic [NSEND-1:0] to_me;
    for (genvar s = 0; s < NSEND; s++) begin : g_to
      assign to_me[s] = granted[s] && cmd[s].target == TGT_W'(c);
    end

    // R8
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(to_me));

    ipi_core_regs u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (hit[c]),
      .cmd       (core_cmd[c]),
      .reg_we    (reg_we[c]),
      .reg_addr  (reg_addr[c*8 +: 8]),
      .reg_wdata (reg_wdata[c*WORD_W +: WORD_W]),
      .reg_rdata (reg_rdata[c*WORD_W +: WORD_W]),
      .irq       (irq[c])
    );
  end
endmodule

// File: tb/tb_ipi_mbox_ctrl.sv
module tb_ipi_mbox_ctrl;
  localparam int NC = 4;
  localparam int NS = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic [NS-1:0]    snd_valid = '0, snd_size8 = '0, snd_ready;
  logic [NS*8-1:0]  snd_addr = '0;
  logic [NS*64-1:0] snd_data = '0;
  logic [NC-1:0]    reg_we = '0, irq;
  logic [NC*8-1:0]  reg_addr = '0;
  logic [NC*32-1:0] reg_wdata = '0, reg_rdata;

  always #5 clk = ~clk;

  ipi_mbox_ctrl #(.NCORES(NC), .NSEND(NS)) dut (.*);

  int errors = 0, checks = 0;
  bit done = 0;
  logic [31:0] m_stat [NC];
  logic [31:0] m_en   [NC];
  logic [31:0] m_mb   [NC][8];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input int tgt, input logic [4:0] low,
                                     input logic [3:0] keep, input logic [31:0] pay);
    logic [63:0] d = '0;
    d[63:32] = pay; d[30:27] = keep; d[25:16] = 10'(tgt); d[4:0] = low;
    return d;
  endfunction

  // 0 none, 1 ipi, 2 mail
  function automatic int kind_of(input logic [7:0] a, input logic sz, input logic [63:0] d);
    if (int'(d[25:16]) >= NC) return 0;
    if (a == 8'h00) return 1;
    if (a == 8'h08 && sz) return 2;
    return 0;
  endfunction

  function automatic logic [31:0] merge_ref(input logic [31:0] o, input logic [31:0] p,
                                            input logic [3:0] k);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = k[b] ? o[8*b +: 8] : p[8*b +: 8];
    return r;
  endfunction

  function automatic logic [31:0] reg_ref(input int c, input logic [7:0] a);
    if (a == 8'h00) return m_stat[c];
    if (a == 8'h04) return m_en[c];
    if (a >= 8'h20 && a <= 8'h3C && a[1:0] == 0) return m_mb[c][a[4:2]];
    return 32'h0;
  endfunction

  task automatic put_send(input int s, input logic [7:0] a, input logic sz, input logic [63:0] d);
    snd_valid[s] = 1'b1; snd_size8[s] = sz; snd_addr[s*8 +: 8] = a; snd_data[s*64 +: 64] = d;
  endtask

  task automatic put_reg(input int c, input logic [7:0] a, input logic [31:0] w);
    reg_we[c] = 1'b1; reg_addr[c*8 +: 8] = a; reg_wdata[c*32 +: 32] = w;
  endtask

  // Caller is at a negedge with inputs set
  task automatic do_cycle(input string req);
    int k [NS];
    int t [NS];
    logic [NS-1:0] rdy;
    logic [31:0] setb [NC];
    #1;
    for (int s = 0; s < NS; s++) begin
      k[s] = snd_valid[s] ? kind_of(snd_addr[s*8 +: 8], snd_size8[s], snd_data[s*64 +: 64]) : 0;
      t[s] = int'(snd_data[s*64+16 +: 10]);
    end
    for (int s = 0; s < NS; s++) begin
      rdy[s] = 1'b1;
      if (k[s] != 0)
        for (int u = 0; u < s; u++) if (k[u] != 0 && t[u] == t[s]) rdy[s] = 1'b0;
      if (snd_valid[s]) chk({req, " ready"}, 32'(snd_ready[s]), 32'(rdy[s]));
    end
    for (int c = 0; c < NC; c++) setb[c] = '0;
    for (int s = 0; s < NS; s++) begin
      if (k[s] != 0 && rdy[s]) begin
        logic [63:0] d = snd_data[s*64 +: 64];
        if (k[s] == 1) setb[t[s]] = 32'h1 << d[4:0];
        else m_mb[t[s]][d[4:2]] = merge_ref(m_mb[t[s]][d[4:2]], d[63:32], d[30:27]);
      end
    end
    for (int c = 0; c < NC; c++) begin
      if (reg_we[c] && reg_addr[c*8 +: 8] == 8'h08) m_stat[c] = m_stat[c] & ~reg_wdata[c*32 +: 32];
      if (reg_we[c] && reg_addr[c*8 +: 8] == 8'h04) m_en[c] = reg_wdata[c*32 +: 32];
      m_stat[c] = m_stat[c] | setb[c];
    end
    @(posedge clk); #1;
    snd_valid = '0; reg_we = '0;
  endtask

  task automatic rd(input string req, input int c, input logic [7:0] a);
    @(negedge clk);
    reg_addr[c*8 +: 8] = a;
    #1 chk(req, reg_rdata[c*32 +: 32], reg_ref(c, a));
  endtask

  task automatic chk_irq(input string req);
    logic [NC-1:0] e;
    @(negedge clk);
    for (int c = 0; c < NC; c++) e[c] = |(m_stat[c] & m_en[c]);
    chk(req, 32'(irq), 32'(e));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < NC; c++) begin
      m_stat[c] = '0; m_en[c] = '1;
      for (int i = 0; i < 8; i++) m_mb[c][i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    for (int c = 0; c < NC; c++) begin
      rd("R1 status", c, 8'h00); rd("R1 enable", c, 8'h04); rd("R1 mbox", c, 8'h3C);
    end
    chk_irq("R1 irq");

    // R2 ipi send, narrow access
    @(negedge clk); put_send(0, 8'h00, 1'b0, mk(2, 5'd17, 4'h0, 32'h0)); do_cycle("R2");
    rd("R2 status", 2, 8'h00); chk_irq("R3 irq after ipi");
    // R3 enable masks irq
    @(negedge clk); put_reg(2, 8'h04, 32'hFFFD_FFFF); do_cycle("R3");
    chk_irq("R3 masked"); rd("R3 enable rd", 2, 8'h04);
    // R4 clear with same-cycle set of the same bit: set wins
    @(negedge clk); put_reg(1, 8'h08, 32'hFFFF_FFFF);
    put_send(0, 8'h00, 1'b1, mk(1, 5'd3, 4'h0, 32'h0)); do_cycle("R4");
    rd("R4 set wins", 1, 8'h00); rd("R4 clr reads zero", 1, 8'h08);
    @(negedge clk); put_reg(2, 8'h08, 32'h0002_0000); do_cycle("R4");
    rd("R4 cleared", 2, 8'h00);
    // R5 full write, R6 merge
    @(negedge clk); put_send(1, 8'h08, 1'b1, mk(3, 5'd20, 4'h0, 32'hA1B2C3D4)); do_cycle("R5");
    rd("R5 mbox", 3, 8'h34);
    @(negedge clk); put_send(0, 8'h08, 1'b1, mk(3, 5'd20, 4'b0101, 32'h11223344)); do_cycle("R6");
    rd("R6 merge", 3, 8'h34);
    // R7 ignored commands
    @(negedge clk); put_send(0, 8'h08, 1'b0, mk(3, 5'd20, 4'h0, 32'hDEADBEEF)); do_cycle("R7 narrow");
    rd("R7 narrow no effect", 3, 8'h34);
    @(negedge clk); put_send(0, 8'h18, 1'b1, mk(0, 5'd0, 4'h0, 32'h5)); do_cycle("R7 bad offset");
    rd("R7 offset no effect", 0, 8'h20); rd("R7 offset no status", 0, 8'h00);
    @(negedge clk); put_send(1, 8'h00, 1'b1, mk(7, 5'd1, 4'h0, 32'h0)); do_cycle("R7 bad target");
    // R8 conflict and parallel
    @(negedge clk); put_send(0, 8'h08, 1'b1, mk(0, 5'd4, 4'h0, 32'h0000AAAA));
    put_send(1, 8'h08, 1'b1, mk(0, 5'd4, 4'h0, 32'h0000BBBB)); do_cycle("R8 conflict");
    rd("R8 winner data", 0, 8'h24);
    @(negedge clk); put_send(0, 8'h00, 1'b1, mk(0, 5'd9, 4'h0, 32'h0));
    put_send(1, 8'h00, 1'b1, mk(1, 5'd9, 4'h0, 32'h0)); do_cycle("R8 parallel");
    rd("R8 core0", 0, 8'h00); rd("R8 core1", 1, 8'h00);
    // R9 unmapped read
    rd("R9 unmapped", 1, 8'h44); rd("R9 unmapped", 1, 8'h22);

    for (int it = 0; it < 400; it++) begin
      @(negedge clk);
      for (int s = 0; s < NS; s++) begin
        if ($urandom_range(0, 3) != 0) begin
          logic [7:0] a;
          case ($urandom_range(0, 3))
            0: a = 8'h00; 1, 2: a = 8'h08; default: a = 8'h10;
          endcase
          put_send(s, a, 1'($urandom_range(0, 4) != 0),
                   mk($urandom_range(0, 5), 5'($urandom), 4'($urandom), $urandom));
        end
      end
      if ($urandom_range(0, 3) == 0) begin
        int c = $urandom_range(0, NC - 1);
        put_reg(c, ($urandom_range(0, 1) != 0) ? 8'h08 : 8'h04, $urandom | $urandom);
      end
      do_cycle("R8 random");
      chk_irq("R3 random");
      begin
        int c = $urandom_range(0, NC - 1);
        int pick = $urandom_range(0, 11);
        logic [7:0] a = (pick < 8) ? 8'(8'h20 + 4 * pick) : (pick == 8) ? 8'h00 :
                        (pick == 9) ? 8'h04 : (pick == 10) ? 8'h08 : 8'h4C;
        rd("R6 random readback", c, a);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule